// File: doc/BRIEF.md
# Bidirectional Funnel Shift Unit

This block is a purely combinational N-bit shifter. One data word enters with a shift count, a direction bit and a two-bit mode code, and the shifted word leaves on the same evaluation. Three families of shift are offered in either direction: zero-filling, sign-filling and circular. All six use one shared datapath.

The datapath first forms a 2N-1 bit funnel. It places the data word at one end and the fill bits for the chosen mode at the other. It then slides an N-bit window across that funnel. The window position is set by a cascade of 2-input multiplexer stages, one stage per bit of the window offset, so the count needs no decoder. A right shift uses the count directly as the offset. A left shift puts the data in the upper half of the funnel and selects at offset (N-1)-k. When N is a power of two that offset is the bitwise inverse of k. For other widths a small subtractor forms it.

The count must stay in the range 0 to N-1. Larger counts are outside the contract.

Top module: `funnel_shift_unit`

## Requirements
- R1: With `dir_left_i`=0 and `mode_i`=2'b00 (zero fill), bit i of the result is data bit i+k when i+k < N and 0 otherwise.
- R2: With `dir_left_i`=0 and `mode_i`=2'b01 (sign fill), bit i of the result is data bit i+k when i+k < N and data bit N-1 otherwise.
- R3: With `dir_left_i`=0 and `mode_i`=2'b10 (circular), bit i of the result is data bit (i+k) mod N.
- R4: With `dir_left_i`=1 and `mode_i`=2'b00, bit i of the result is data bit i-k when i >= k and 0 otherwise.
- R5: With `dir_left_i`=1 and `mode_i`=2'b01, the result equals the R4 result for the same data and count.
- R6: With `dir_left_i`=1 and `mode_i`=2'b10, bit i of the result is data bit (i-k) mod N.
- R7: A count of 0 returns the data word unchanged for every direction and every mode code.
- R8: The spare mode code 2'b11 behaves exactly like the zero-fill code 2'b00 in both directions.
- R9: For N=4, data 1011 and count 1: zero-fill right gives 0101, sign-fill right gives 1101, circular right gives 1101, zero-fill left and sign-fill left give 0110, and circular left gives 0111.
- R10: Widths that are not a power of two, for example N=6, follow R1 to R8 for every count from 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | N | Word to be shifted |
| amt_i | input | AW ($clog2(N)) | Shift count k, 0 to N-1 |
| dir_left_i | input | 1 | 0 shifts toward bit 0, 1 shifts toward bit N-1 |
| mode_i | input | 2 | 00 zero fill, 01 sign fill, 10 circular, 11 same as 00 |
| result_o | output | N | Shifted word |

## Verification
On every evaluation, the embedded assertions check several properties. A zero count must pass the data straight through. The vacated top bit after a zero-fill right shift must be 0. A sign-fill right shift must keep the top bit. A circular shift must preserve the number of set bits. The vacated bottom bit after a non-circular left shift must be 0. The window extractor is also checked to return the low funnel bits at offset 0. None of these properties pins down where each individual bit lands. Exact bit placement, equal results between the sign-fill-left and zero-fill-left codes, the spare mode code and the non-power-of-two subtractor path can only be shown by the bench. The bench compares full words against an independent bit-by-bit model, at three widths.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

   typedef enum logic [1:0] {
      FSH_ZERO   = 2'b00,
      FSH_SIGN   = 2'b01,
      FSH_CIRC   = 2'b10,
      FSH_SPARE  = 2'b11
   } fsh_mode_e;

endpackage

// File: rtl/fsh_funnel_build.sv
module fsh_funnel_build #(
   parameter int N = 32
) (
   input  logic [N-1:0]     data_i,
   input  logic             dir_left_i,
   input  logic [1:0]       mode_i,
   output logic [2*N-2:0]   funnel_o
);
   import fsh_pkg::*;

   localparam int FILL_W = N - 1;

   logic [FILL_W-1:0] fill;

   // Fill bits: circular modes reuse the data, sign fill only matters on right shifts
   always_comb begin
      unique case (fsh_mode_e'(mode_i))
         FSH_CIRC: fill = dir_left_i ? data_i[N-1:1] : data_i[N-2:0];
         FSH_SIGN: fill = dir_left_i ? '0 : {FILL_W{data_i[N-1]}};
         default:  fill = '0;
      endcase
   end

   // Right: data low, fill high. Left: data high, fill low.
   assign funnel_o = dir_left_i ? {data_i, fill} : {fill, data_i};

endmodule

// File: rtl/fsh_offset.sv
module fsh_offset #(
   parameter int N  = 32,
   parameter int AW = 5
) (
   input  logic [AW-1:0] amt_i,
   input  logic          dir_left_i,
   output logic [AW-1:0] off_o
);
   localparam bit POW2 = (N == (1 << AW));
   localparam logic [AW-1:0] TOP = AW'(N - 1);

   generate
      if (POW2) begin : g_invert
         // (N-1)-k equals ~k when N-1 is all ones
         assign off_o = dir_left_i ? ~amt_i : amt_i;
      end else begin : g_subtract
         assign off_o = dir_left_i ? (TOP - amt_i) : amt_i;
      end
   endgenerate

endmodule

// File: rtl/fsh_window.sv
module fsh_window #(
   parameter int N  = 32,
   parameter int AW = 5
) (
   input  logic [2*N-2:0] funnel_i,
   input  logic [AW-1:0]  off_i,
   output logic [N-1:0]   win_o
);
   localparam int FW = 2 * N - 1;
   localparam int PW = N + (1 << AW) - 1;

   logic [PW-1:0] padded;
   assign padded = PW'(funnel_i);

   // Highest offset bit first; each stage narrows to what later stages can still reach
   generate
      for (genvar b = AW - 1; b >= 0; b--) begin : g_stage
         localparam int WI = N + (2 << b) - 1;
         localparam int WO = N + (1 << b) - 1;
         logic [WI-1:0] vin;
         logic [WO-1:0] vout;
         if (b == AW - 1) begin : g_first
            assign vin = padded;
         end else begin : g_next
            assign vin = g_stage[b+1].vout;
         end
         assign vout = off_i[b] ? vin[(1 << b) +: WO] : vin[WO-1:0];
      end
   endgenerate

   assign win_o = g_stage[0].vout;

   always_comb begin
      if (off_i == '0)
         a_r7_window_origin: assert (win_o == funnel_i[N-1:0])
            else $error("window at offset 0 differs from funnel low bits");
   end

   generate
      if (PW < FW) begin : g_bad_pad
         $error("fsh_window: padded width below funnel width");
      end
   endgenerate

endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
   parameter int N  = 32,
   parameter int AW = $clog2(N)
) (
   input  logic [N-1:0]  data_i,
   input  logic [AW-1:0] amt_i,
   input  logic          dir_left_i,
   input  logic [1:0]    mode_i,
   output logic [N-1:0]  result_o
);
   import fsh_pkg::*;

   localparam int FW = 2 * N - 1;

   generate
      if (N < 2) begin : g_bad_width
         $error("funnel_shift_unit: N must be at least 2");
      end
      if (AW != $clog2(N)) begin : g_bad_aw
         $error("funnel_shift_unit: AW must equal clog2(N)");
      end
   endgenerate

   logic [FW-1:0] funnel;
   logic [AW-1:0] off;

   fsh_funnel_build #(.N(N)) u_build (
      .data_i     (data_i),
      .dir_left_i (dir_left_i),
      .mode_i     (mode_i),
      .funnel_o   (funnel)
   );

   fsh_offset #(.N(N), .AW(AW)) u_offset (
      .amt_i      (amt_i),
      .dir_left_i (dir_left_i),
      .off_o      (off)
   );

   fsh_window #(.N(N), .AW(AW)) u_window (
      .funnel_i   (funnel),
      .off_i      (off),
      .win_o      (result_o)
   );

   always_comb begin
      if (amt_i == '0)
         a_r7_zero_pass: assert (result_o == data_i)
            else $error("R7 count 0 altered data");
      if (!dir_left_i && mode_i == FSH_ZERO && amt_i != '0)
         a_r1_top_cleared: assert (result_o[N-1] == 1'b0)
            else $error("R1 vacated top bit not zero");
      if (!dir_left_i && mode_i == FSH_SIGN)
         a_r2_sign_kept: assert (result_o[N-1] == data_i[N-1])
            else $error("R2 sign bit lost");
      if (mode_i == FSH_CIRC)
         a_r3_ones_kept: assert ($countones(result_o) == $countones(data_i))
            else $error("R3/R6 circular shift changed bit count");
      if (dir_left_i && mode_i != FSH_CIRC && amt_i != '0)
         a_r4_low_cleared: assert (result_o[0] == 1'b0)
            else $error("R4 vacated low bit not zero");
   end

endmodule

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [31:0] d32;  logic [4:0] k32;  logic [31:0] r32;
   logic [3:0]  d4;   logic [1:0] k4;   logic [3:0]  r4;
   logic [5:0]  d6;   logic [2:0] k6;   logic [5:0]  r6;
   logic        dir_l;
   logic [1:0]  mode;

   funnel_shift_unit #(.N(32)) u_funnel_shift_unit (
      .data_i(d32), .amt_i(k32), .dir_left_i(dir_l), .mode_i(mode), .result_o(r32));
   funnel_shift_unit #(.N(4)) u_funnel_shift_unit_n4 (
      .data_i(d4), .amt_i(k4), .dir_left_i(dir_l), .mode_i(mode), .result_o(r4));
   funnel_shift_unit #(.N(6)) u_funnel_shift_unit_n6 (
      .data_i(d6), .amt_i(k6), .dir_left_i(dir_l), .mode_i(mode), .result_o(r6));

   typedef struct {
      logic [31:0] e32;
      logic [3:0]  e4;
      logic [5:0]  e6;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Bit-by-bit model written from the requirements
   function automatic logic [31:0] model(input logic [31:0] d, input int n, input int k,
                                         input logic left, input logic [1:0] m);
      logic [31:0] o = '0;
      for (int i = 0; i < n; i++) begin
         int src;
         if (!left) begin
            src = i + k;
            if (src < n)            o[i] = d[src];
            else if (m == 2'b01)    o[i] = d[n-1];
            else if (m == 2'b10)    o[i] = d[src-n];
            else                    o[i] = 1'b0;
         end else begin
            src = i - k;
            if (src >= 0)           o[i] = d[src];
            else if (m == 2'b10)    o[i] = d[src+n];
            else                    o[i] = 1'b0;
         end
      end
      return o;
   endfunction

   function automatic string req_of(input logic left, input logic [1:0] m, input int k);
      if (k == 0)    return "R7";
      if (m == 2'b11) return "R8";
      case ({left, m})
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b010:  return "R3";
         3'b100:  return "R4";
         3'b101:  return "R5";
         default: return "R6";
      endcase
   endfunction

   // Driver: applies one vector per cycle and queues its expected results
   task automatic drive(input logic [31:0] d, input int k, input logic left,
                        input logic [1:0] m, input string tag);
      exp_t e;
      @(posedge clk); #1;
      d32 = d;        k32 = 5'(k % 32);
      d4  = d[3:0];   k4  = 2'(k % 4);
      d6  = d[5:0];   k6  = 3'(k % 6);
      dir_l = left;   mode = m;
      e.e32 = model(d, 32, k % 32, left, m);
      e.e4  = 4'(model({28'd0, d[3:0]}, 4, k % 4, left, m));
      e.e6  = 6'(model({26'd0, d[5:0]}, 6, k % 6, left, m));
      e.tag = (tag == "") ? req_of(left, m, k % 32) : tag;
      sb.push_back(e);
   endtask

   task automatic cmp(input string tag, input int w, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s width=%0d actual=%h expected=%h", tag, w, act, exp);
      end
   endtask

   // Monitor: pops and compares away from the driving edge
   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         cmp(e.tag, 32, r32, e.e32);
         cmp(e.tag, 4,  {28'd0, r4}, {28'd0, e.e4});
         cmp(e.tag, 6,  {26'd0, r6}, {26'd0, e.e6});
      end
   end

   task automatic check_fixed4(input logic left, input logic [1:0] m, input logic [3:0] want);
      @(posedge clk); #1;
      d4 = 4'b1011; k4 = 2'd1; dir_l = left; mode = m;
      d32 = 32'h0; k32 = 5'd0; d6 = 6'd0; k6 = 3'd0;
      #5;
      cmp("R9", 4, {28'd0, r4}, {28'd0, want});
   endtask

   initial begin
      d32 = '0; k32 = '0; d4 = '0; k4 = '0; d6 = '0; k6 = '0; dir_l = 0; mode = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R9: worked 4-bit examples
      check_fixed4(1'b0, 2'b00, 4'b0101);
      check_fixed4(1'b0, 2'b01, 4'b1101);
      check_fixed4(1'b0, 2'b10, 4'b1101);
      check_fixed4(1'b1, 2'b00, 4'b0110);
      check_fixed4(1'b1, 2'b01, 4'b0110);
      check_fixed4(1'b1, 2'b10, 4'b0111);

      // R7: zero count in every mode and direction
      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 2; l++)
            drive(32'hA5C3_9E17, 0, l[0], m[1:0], "R7");

      // Sweep every count on edge patterns, all modes (R1..R6, R8)
      for (int p = 0; p < 4; p++) begin
         logic [31:0] pat;
         pat = (p == 0) ? 32'h8000_0001 : (p == 1) ? 32'hFFFF_FFFF :
               (p == 2) ? 32'h7FFF_FFFE : 32'hF0E1_D2C3;
         for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
               for (int k = 0; k < 32; k++)
                  drive(pat, k, l[0], m[1:0], "");
      end

      // R10: every legal count at width 6 (k below 6 keeps all widths in range)
      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 2; l++)
            for (int k = 0; k < 6; k++)
               drive(32'h0000_002D, k, l[0], m[1:0], "R10");

      // Random vectors
      for (int i = 0; i < 800; i++) begin
         logic [31:0] rd;
         int rk;
         rd = $urandom;
         rk = int'($urandom_range(0, 31));
         drive(rd, rk, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "");
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before stimulus completed");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule